// File: doc/BRIEF.md
# Stack Pointer Push/Pop Sequencer

This block holds the 8-bit stack pointer of a small 8-bit processor and runs the byte transfers that move return addresses, status and registers to and from the stack. The stack sits in one fixed 256-byte page of data memory. The effective address of every stack access is the page byte followed by the pointer. The core sends a one-cycle request for a subroutine call, an interrupt entry, a single-register push, a subroutine return, an interrupt return or a single-register pop. The block then issues one memory strobe per clock until the whole sequence is done. It tags every transfer with what it carries, so the core can steer popped bytes into the status word, the program counter halves or the register file.

A save writes at the current pointer and then moves the pointer down. A restore moves the pointer up first and then reads. Reset does not set the pointer. Software must load it, normally with FEH, before it uses the stack. A sticky warning flag shows that a save has wrapped the pointer from 00H to FFH, because the next save would then hit the forbidden top location of the page.

Top module: `stack_seq`

## Requirements
- R1: Every stack access drives `mem_addr` as {PAGE, pointer byte}, with PAGE = 8'h01 by default.
- R2: A save (`mem_wr` high) writes at the current `sp_out`, and `sp_out` is one less at the next cycle.
- R3: A restore (`mem_rd` high) reads at `sp_out`+1, and `sp_out` takes that value at the next cycle.
- R4: A call stores PC[15:8] and then PC[7:0] in two consecutive write cycles, tagged `xfer_kind` 3 (PCH) and then 2 (PCL).
- R5: An interrupt entry stores PCH, then PCL, then the status word, tagged 3, 2 and then 1 (PSW), in three consecutive write cycles.
- R6: A return reads with tags PCL and then PCH. An interrupt return reads with tags PSW, then PCL, then PCH. Each read byte appears on `pop_data` with `pop_valid` high in the same cycle.
- R7: A single push writes `reg_data` once, and a single pop reads once. Both use tag 0 (REG).
- R8: `ld_sp` while idle sets `sp_out` to `ld_val` at the next cycle. Reset does not initialise the pointer, and an idle pointer holds its value.
- R9: `busy` goes high in the cycle after a request is accepted and stays high for exactly one cycle per transfer. `mem_rd` and `mem_wr` are never high together, and neither is high while `busy` is low.
- R10: `wrap_warn` is 0 after reset, rises after a save made with the pointer at 00H, and stays set until the next accepted load.
- R11: Requests and loads that arrive while `busy` is high are ignored. When several arrive together while idle, only one is taken, in the priority order load, call, interrupt entry, push, return, interrupt return, pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_call | input | 1 | Subroutine call request pulse |
| req_irq | input | 1 | Interrupt entry request pulse |
| req_push | input | 1 | Single-register push request pulse |
| req_ret | input | 1 | Subroutine return request pulse |
| req_reti | input | 1 | Interrupt return request pulse |
| req_pop | input | 1 | Single-register pop request pulse |
| ld_sp | input | 1 | Load the pointer from `ld_val` |
| ld_val | input | 8 | Value for a pointer load, taken from the index register |
| pc_in | input | 16 | Program counter to save, captured when the request is accepted |
| psw_in | input | 8 | Status word to save, captured when the request is accepted |
| reg_data | input | 8 | Register byte to push, captured when the request is accepted |
| mem_rd | output | 1 | Stack read strobe |
| mem_wr | output | 1 | Stack write strobe |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Byte being written |
| mem_rdata | input | 8 | Byte read, valid in the cycle `mem_rd` is high |
| xfer_kind | output | 2 | Tag of the current transfer: 0 REG, 1 PSW, 2 PCL, 3 PCH |
| pop_valid | output | 1 | A restored byte is on `pop_data` |
| pop_data | output | 8 | Restored byte |
| busy | output | 1 | A sequence is in progress |
| sp_out | output | 8 | Current stack pointer |
| wrap_warn | output | 1 | Sticky flag: a save wrapped the pointer from 00H to FFH |

## Verification
A wrong pointer shows at the ports in the same transfer cycle, as a wrong `mem_addr` low byte. It also shows one cycle later as a wrong `sp_out`. A broken step counter or byte order shows up as the wrong `xfer_kind` or wrong data in the affected transfer cycle. It also shows as `busy` staying high one cycle too long or dropping one cycle too early. Pushed data is read back through later pops against a bench memory image, so a corrupted write is caught at the first restore of that location. Its position in the pop order shows which save went wrong.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int          SP_W   = 8,
  parameter int          PAGE_W = 8,
  parameter logic [7:0]  PAGE   = 8'h01
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_call,
  input  logic                     req_irq,
  input  logic                     req_push,
  input  logic                     req_ret,
  input  logic                     req_reti,
  input  logic                     req_pop,
  input  logic                     ld_sp,
  input  logic [SP_W-1:0]          ld_val,
  input  logic [15:0]              pc_in,
  input  logic [7:0]               psw_in,
  input  logic [7:0]               reg_data,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic [PAGE_W+SP_W-1:0]   mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata,
  output logic [1:0]               xfer_kind,
  output logic                     pop_valid,
  output logic [7:0]               pop_data,
  output logic                     busy,
  output logic [SP_W-1:0]          sp_out,
  output logic                     wrap_warn
);
  typedef enum logic [2:0] {OP_CALL, OP_IRQ, OP_PUSH, OP_RET, OP_RETI, OP_POP} op_t;
  localparam logic [1:0] K_REG = 2'd0, K_PSW = 2'd1, K_PCL = 2'd2, K_PCH = 2'd3;

  logic [SP_W-1:0] sp;
  logic            active;
  op_t             op;
  logic [1:0]      step;
  logic [15:0]     pc_q;
  logic [7:0]      psw_q, dat_q;
  logic            is_rd, last;
  logic            any_req, take_ld;
  op_t             new_op;

  assign any_req = req_call | req_irq | req_push | req_ret | req_reti | req_pop;
  assign take_ld = !active && ld_sp;

  always_comb begin
    if      (req_call) new_op = OP_CALL;
    else if (req_irq)  new_op = OP_IRQ;
    else if (req_push) new_op = OP_PUSH;
    else if (req_ret)  new_op = OP_RET;
    else if (req_reti) new_op = OP_RETI;
    else               new_op = OP_POP;
  end

  always_comb begin
    is_rd     = 1'b0;
    last      = 1'b1;
    xfer_kind = K_REG;
    case (op)
      OP_CALL: begin
        xfer_kind = (step == 2'd0) ? K_PCH : K_PCL;
        last      = (step == 2'd1);
      end
      OP_IRQ: begin
        xfer_kind = (step == 2'd0) ? K_PCH : (step == 2'd1) ? K_PCL : K_PSW;
        last      = (step == 2'd2);
      end
      OP_RET: begin
        is_rd     = 1'b1;
        xfer_kind = (step == 2'd0) ? K_PCL : K_PCH;
        last      = (step == 2'd1);
      end
      OP_RETI: begin
        is_rd     = 1'b1;
        xfer_kind = (step == 2'd0) ? K_PSW : (step == 2'd1) ? K_PCL : K_PCH;
        last      = (step == 2'd2);
      end
      OP_POP:  is_rd = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (xfer_kind)
      K_PCH:   mem_wdata = pc_q[15:8];
      K_PCL:   mem_wdata = pc_q[7:0];
      K_PSW:   mem_wdata = psw_q;
      default: mem_wdata = dat_q;
    endcase
  end

  assign busy      = active;
  assign mem_rd    = active &&  is_rd;
  assign mem_wr    = active && !is_rd;
  assign mem_addr  = {PAGE[PAGE_W-1:0], is_rd ? sp + SP_W'(1) : sp};
  assign pop_valid = mem_rd;
  assign pop_data  = mem_rd ? mem_rdata : 8'h00;
  assign sp_out    = sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      op        <= OP_PUSH;
      step      <= 2'd0;
      pc_q      <= '0;
      psw_q     <= '0;
      dat_q     <= '0;
      wrap_warn <= 1'b0;
    end else if (active) begin
      step   <= step + 2'd1;
      if (last) active <= 1'b0;
      if (mem_wr && sp == '0) wrap_warn <= 1'b1;
    end else if (take_ld) begin
      wrap_warn <= 1'b0;
    end else if (any_req) begin
      active <= 1'b1;
      op     <= new_op;
      step   <= 2'd0;
      pc_q   <= pc_in;
      psw_q  <= psw_in;
      dat_q  <= reg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (take_ld)     sp <= ld_val;
    else if (mem_wr) sp <= sp - SP_W'(1);
    else if (mem_rd) sp <= sp + SP_W'(1);
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int         SP_W   = 8,
  parameter int         PAGE_W = 8,
  parameter logic [7:0] PAGE   = 8'h01
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ld_sp,
  input logic                   busy,
  input logic                   mem_rd,
  input logic                   mem_wr,
  input logic [PAGE_W+SP_W-1:0] mem_addr,
  input logic [SP_W-1:0]        sp_out,
  input logic                   wrap_warn
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else if (ld_sp && !busy) seen <= 1'b1;

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> mem_addr[PAGE_W+SP_W-1:SP_W] == PAGE[PAGE_W-1:0]); // R1
  AST_SAVE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && mem_wr) |=> sp_out == SP_W'($past(mem_addr[SP_W-1:0]) - SP_W'(1))); // R2
  AST_RESTORE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && mem_rd) |=> sp_out == $past(mem_addr[SP_W-1:0])); // R3
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !busy && !ld_sp) |=> $stable(sp_out)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr)); // R9
  AST_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && mem_wr && mem_addr[SP_W-1:0] == '0) |=> wrap_warn); // R10
endmodule

bind stack_seq stack_seq_chk #(.SP_W(SP_W), .PAGE_W(PAGE_W), .PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_sp(ld_sp), .busy(busy), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .sp_out(sp_out), .wrap_warn(wrap_warn)
);

// File: tb/stack_seq_tb.sv
`timescale 1ns/100ps
module stack_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_call = 0, req_irq = 0, req_push = 0, req_ret = 0, req_reti = 0, req_pop = 0;
  logic ld_sp = 0;
  logic [7:0] ld_val = 0, psw_in = 0, reg_data = 0;
  logic [15:0] pc_in = 0;
  logic mem_rd, mem_wr, pop_valid, busy, wrap_warn;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, pop_data, sp_out;
  logic [1:0] xfer_kind;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] m_sp;
  logic loaded = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_call(req_call), .req_irq(req_irq), .req_push(req_push),
    .req_ret(req_ret), .req_reti(req_reti), .req_pop(req_pop), .ld_sp(ld_sp), .ld_val(ld_val),
    .pc_in(pc_in), .psw_in(psw_in), .reg_data(reg_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .xfer_kind(xfer_kind),
    .pop_valid(pop_valid), .pop_data(pop_data), .busy(busy), .sp_out(sp_out), .wrap_warn(wrap_warn)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  always @(negedge clk)
    if ((mem_rd || mem_wr) && !loaded) begin
      errors++;
      $display("FAIL R8 stack access before first load got 1 exp 0");
    end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, act, exp);
    end
  endtask

  // op: 0 call 1 irq 2 push 3 ret 4 reti 5 pop
  function automatic int len_of(int op);
    case (op) 0, 3: return 2; 1, 4: return 3; default: return 1; endcase
  endfunction
  function automatic int kind_of(int op, int s);
    case (op)
      0: return s == 0 ? 3 : 2;
      1: return s == 0 ? 3 : (s == 1 ? 2 : 1);
      3: return s == 0 ? 2 : 3;
      4: return s == 0 ? 1 : (s == 1 ? 2 : 3);
      default: return 0;
    endcase
  endfunction
  function automatic int prio(logic [5:0] m);
    for (int i = 0; i < 6; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic load(input logic [7:0] v);
    ld_sp = 1; ld_val = v;
    @(negedge clk);
    ld_sp = 0;
    loaded = 1; m_sp = v;
    chk("R8 load", sp_out, v);
  endtask

  task automatic run(input logic [5:0] mask, input logic [15:0] pc, input logic [7:0] psw,
                     input logic [7:0] dat, input bit poke);
    int op, n;
    logic [7:0] wexp, a;
    op = prio(mask);
    {req_pop, req_reti, req_ret, req_push, req_irq, req_call} = mask;
    pc_in = pc; psw_in = psw; reg_data = dat;
    @(negedge clk);
    {req_pop, req_reti, req_ret, req_push, req_irq, req_call} = '0;
    pc_in = ~pc; psw_in = ~psw; reg_data = ~dat;
    n = len_of(op);
    for (int s = 0; s < n; s++) begin
      if (poke && s == 0) begin req_push = 1; ld_sp = 1; ld_val = 8'h33; end
      chk("R9 busy", busy, 1);
      chk("R11 kind", xfer_kind, kind_of(op, s));
      if (op <= 2) begin
        chk("R2 wr strobe", {mem_wr, mem_rd}, 2'b10);
        chk("R1 addr save", mem_addr, {8'h01, m_sp});
        case (kind_of(op, s)) 3: wexp = pc[15:8]; 2: wexp = pc[7:0]; 1: wexp = psw; default: wexp = dat; endcase
        chk(op == 0 ? "R4 data" : op == 1 ? "R5 data" : "R7 data", mem_wdata, wexp);
        ref_mem[m_sp] = wexp;
        m_sp = m_sp - 8'd1;
      end else begin
        a = m_sp + 8'd1;
        chk("R3 rd strobe", {mem_wr, mem_rd}, 2'b01);
        chk("R1 addr restore", mem_addr, {8'h01, a});
        chk("R6 pop_valid", pop_valid, 1);
        chk(op == 5 ? "R7 pop data" : "R6 pop data", pop_data, ref_mem[a]);
        m_sp = a;
      end
      @(negedge clk);
      if (poke && s == 0) begin req_push = 0; ld_sp = 0; end
    end
    chk("R9 busy end", busy, 0);
    chk("R2 R3 sp after", sp_out, m_sp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hang exp finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; ref_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset strobes", {mem_rd, mem_wr}, 0);
    chk("R10 reset warn", wrap_warn, 0);
    rst_n = 1;
    @(negedge clk);
    load(8'hFE);
    // R4 / R6 call then return
    run(6'b000001, 16'hA1B2, 8'h11, 8'h00, 0);
    run(6'b001000, 16'h0, 8'h0, 8'h0, 0);
    // R5 / R6 interrupt entry then return
    run(6'b000010, 16'hC3D4, 8'h5A, 8'h00, 0);
    run(6'b010000, 16'h0, 8'h0, 8'h0, 0);
    // R7 push/pop
    run(6'b000100, 16'h0, 8'h0, 8'h9C, 0);
    run(6'b100000, 16'h0, 8'h0, 8'h0, 0);
    // R11 ignore while busy: push and load poked in first busy cycle
    run(6'b000001, 16'h1357, 8'h0, 8'h0, 1);
    chk("R11 ignored sp", sp_out, 8'hFC);
    run(6'b001000, 16'h0, 8'h0, 8'h0, 0);
    // R11 priority among simultaneous requests
    run(6'b100110, 16'h2468, 8'h77, 8'hEE, 0);
    run(6'b110000, 16'h0, 8'h0, 8'h0, 0);
    // R11 load beats requests
    ld_sp = 1; ld_val = 8'hF0; req_push = 1;
    @(negedge clk);
    ld_sp = 0; req_push = 0; m_sp = 8'hF0;
    chk("R11 load wins busy", busy, 0);
    chk("R11 load wins sp", sp_out, 8'hF0);
    @(negedge clk);
    chk("R8 idle hold", sp_out, 8'hF0);
    // R10 wrap warning
    load(8'h01);
    run(6'b000100, 16'h0, 8'h0, 8'h41, 0);
    chk("R10 no warn at 00", wrap_warn, 0);
    run(6'b000100, 16'h0, 8'h0, 8'h42, 0);
    chk("R10 warn after wrap", wrap_warn, 1);
    chk("R10 sp wrapped", sp_out, 8'hFF);
    run(6'b100000, 16'h0, 8'h0, 8'h0, 0);
    chk("R10 warn sticky", wrap_warn, 1);
    load(8'hFE);
    chk("R10 warn cleared", wrap_warn, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 6));
      if (op == 6) begin
        if (m_sp >= 8'h40 && m_sp <= 8'hF0) load(m_sp);
        continue;
      end
      if (op <= 2 && m_sp < 8'h10) op = op + 3;
      if (op >= 3 && int'(m_sp) + len_of(op) > 254) op = op - 3;
      run(6'b1 << op, 16'($urandom), 8'($urandom), 8'($urandom), 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule